// File: doc/BRIEF.md
# Automated Anti-Collision Slot Scanner

This block runs a complete sixteen-slot anti-collision scan after one trigger, with no further action from the host. The trigger is a write to the slot register. The scan opens with a slot-0 call command. It then sends a slot-marker command for each of slots 1 to 15, in rising order.

After each command the block waits for an answer that carries a chip identifier. It sorts each slot into one of three outcomes:

- a valid answer,
- no answer within the watchdog window,
- an answer with a CRC error.

Each outcome is written into the shared frame buffer. When the scan is over, the buffer holds a fixed nineteen-byte result image: a length byte, two status bytes and sixteen per-slot identifier bytes.

The block uses the transmit request, receive result and buffer write ports of the frame exchange controller. A request carries one command byte. The receive side reports one identifier byte together with a CRC-good flag. The answer timeout comes from the watchdog selection that is currently applied.

Top module: `acs_slot_scan`

## Requirements
- R1: When `scan_start` is sampled high while the block is idle and `xchg_busy` is low, `busy` rises and `tx_req` is high in the next cycle. `tx_req` is never high while `busy` is low.
- R2: Each scan issues exactly 16 single-cycle transmit requests. The first carries `CALL_OPC` (default 06h). Request n (n = 1..15) carries the byte {n[3:0], `MARK_NIB`}, with the slot number in bits 7:4 and `MARK_NIB` (default 6h) in bits 3:0.
- R3: An answer with `rx_crc_ok`=1 sets the status bit of that slot to 1. It also stores `rx_id` at buffer address 3+slot, including the identifier values 00h and FFh.
- R4: If no answer is sampled within the window, status is 0 and address 3+slot gets 00h. The window is LIM(`wdg_sel`) cycles after the request cycle, with defaults 12, 20, 28 and 36 for select 0 to 3. The slot's buffer write then comes LIM+1 cycles after its request. An answer sampled k cycles after the request (k ≤ LIM) is written k+1 cycles after the request.
- R5: An answer with `rx_crc_ok`=0 clears the slot's status bit and stores FFh at address 3+slot.
- R6: After slot 15 the buffer receives three header writes:
  - address 0 gets 18;
  - address 1 gets the status of slots 7..0, with bit i = slot i;
  - address 2 gets the status of slots 15..8, with bit i = slot 8+i.
- R7: `scan_start` has no effect while a scan runs or while `xchg_busy` is high.
- R8: `done` is high for one cycle, together with the address-2 header write. `busy` is low in the following cycle.
- R9: `rx_valid` outside the answer wait of a slot has no effect. This covers the idle state and answers that arrive after the window has closed.
- R10: Each scan writes each of buffer addresses 0 to 18 exactly once and writes no other address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| scan_start | input | 1 | Slot register write strobe |
| xchg_busy | input | 1 | Frame exchange in progress elsewhere |
| wdg_sel | input | 2 | Current watchdog window select |
| tx_req | output | 1 | One-cycle transmit request |
| tx_cmd | output | 8 | Command byte for the request |
| rx_valid | input | 1 | Answer received strobe |
| rx_crc_ok | input | 1 | Answer CRC was good |
| rx_id | input | 8 | Received chip identifier |
| buf_we | output | 1 | Frame buffer write enable |
| buf_addr | output | 5 | Frame buffer byte address |
| buf_wdata | output | 8 | Frame buffer write data |
| busy | output | 1 | Scan in progress |
| done | output | 1 | Scan complete pulse |

## Verification
The assertions check the following on every cycle:
- transmit requests happen only inside a scan and last one cycle;
- a trigger blocked by a running exchange does not start a scan;
- buffer writes stay inside the nineteen-byte image, and address 0 always receives 18;
- `done` coincides with the last header write and is followed by idle.

Only the bench scenarios can show the rest:
- the order of the command bytes;
- the classification of each slot into status bit and sentinel;
- the exact timeout boundary for each watchdog select;
- the packing of status bits into the two header bytes;
- that stray or late answers leave no trace.

// File: rtl/acs_pkg.sv
package acs_pkg;

    localparam int SLOT_CNT  = 16;
    localparam int SLOT_W    = 4;
    localparam int ID_W      = 8;
    localparam int ID_BASE   = 3;
    localparam int LEN_VALUE = 18;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SEND,
        ST_WAIT,
        ST_STORE,
        ST_HDR_LEN,
        ST_HDR_LO,
        ST_HDR_HI
    } scan_state_e;

    typedef enum logic [1:0] {
        OC_NONE,
        OC_VALID,
        OC_CRC
    } outcome_e;

    typedef struct packed {
        outcome_e        oc;
        logic [ID_W-1:0] id;
    } slot_res_t;

    function automatic slot_res_t classify(input logic answered,
                                           input logic crc_ok,
                                           input logic [ID_W-1:0] id);
        slot_res_t r;
        if (!answered) begin
            r.oc = OC_NONE;
            r.id = '0;
        end else if (crc_ok) begin
            r.oc = OC_VALID;
            r.id = id;
        end else begin
            r.oc = OC_CRC;
            r.id = '1;
        end
        return r;
    endfunction

    function automatic logic [7:0] slot_cmd(input logic [SLOT_W-1:0] slot,
                                            input logic [7:0] call_opc,
                                            input logic [3:0] mark_nib);
        return (slot == '0) ? call_opc : {slot, mark_nib};
    endfunction

    function automatic int max_of4(input int a, input int b, input int c, input int d);
        int m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        if (d > m) m = d;
        return m;
    endfunction

endpackage

// File: rtl/acs_wdog.sv
module acs_wdog #(
    parameter int LIM0  = 12,
    parameter int LIM1  = 20,
    parameter int LIM2  = 28,
    parameter int LIM3  = 36,
    parameter int CNT_W = 6
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       clr,
    input  logic       run,
    input  logic [1:0] sel,
    output logic       expired
);
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] last_val;

    always_comb begin
        case (sel)
            2'd0:    last_val = CNT_W'(LIM0 - 1);
            2'd1:    last_val = CNT_W'(LIM1 - 1);
            2'd2:    last_val = CNT_W'(LIM2 - 1);
            default: last_val = CNT_W'(LIM3 - 1);
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst || clr)
            cnt <= '0;
        else if (run && cnt != last_val)
            cnt <= cnt + 1'b1;
    end

    assign expired = run && (cnt == last_val);
endmodule

// File: rtl/acs_slot_ctr.sv
module acs_slot_ctr
    import acs_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              adv,
    output logic [SLOT_W-1:0] slot,
    output logic              last
);
    always_ff @(posedge clk) begin
        if (rst || clr)
            slot <= '0;
        else if (adv)
            slot <= slot + 1'b1;
    end

    assign last = (slot == SLOT_W'(SLOT_CNT - 1));
endmodule

// File: rtl/acs_status_reg.sv
module acs_status_reg
    import acs_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                clr,
    input  logic                set_en,
    input  logic [SLOT_W-1:0]   slot,
    input  logic                ok,
    output logic [SLOT_CNT-1:0] status
);
    for (genvar g = 0; g < SLOT_CNT; g++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst || clr)
                status[g] <= 1'b0;
            else if (set_en && slot == SLOT_W'(g))
                status[g] <= ok;
        end
    end
endmodule

// File: rtl/acs_slot_scan.sv
module acs_slot_scan
    import acs_pkg::*;
#(
    parameter logic [7:0] CALL_OPC = 8'h06,
    parameter logic [3:0] MARK_NIB = 4'h6,
    parameter int         LIM0     = 12,
    parameter int         LIM1     = 20,
    parameter int         LIM2     = 28,
    parameter int         LIM3     = 36,
    parameter int         ADDR_W   = 5
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            scan_start,
    input  logic            xchg_busy,
    input  logic [1:0]      wdg_sel,
    output logic            tx_req,
    output logic [7:0]      tx_cmd,
    input  logic            rx_valid,
    input  logic            rx_crc_ok,
    input  logic [ID_W-1:0] rx_id,
    output logic            buf_we,
    output logic [ADDR_W-1:0] buf_addr,
    output logic [7:0]      buf_wdata,
    output logic            busy,
    output logic            done
);
    localparam int MAX_LIM = max_of4(LIM0, LIM1, LIM2, LIM3);
    localparam int CNT_W   = $clog2(MAX_LIM + 1);

    scan_state_e          st, st_n;
    slot_res_t            res_q;
    logic [SLOT_W-1:0]    slot;
    logic                 last_slot;
    logic [SLOT_CNT-1:0]  status;
    logic                 wd_exp;
    logic                 launch;

    assign launch = (st == ST_IDLE) && scan_start && !xchg_busy;

    always_ff @(posedge clk) begin
        if (rst) st <= ST_IDLE;
        else     st <= st_n;
    end

    always_comb begin
        st_n = st;
        case (st)
            ST_IDLE:    if (launch) st_n = ST_SEND;
            ST_SEND:    st_n = ST_WAIT;
            ST_WAIT:    if (rx_valid || wd_exp) st_n = ST_STORE;
            ST_STORE:   st_n = last_slot ? ST_HDR_LEN : ST_SEND;
            ST_HDR_LEN: st_n = ST_HDR_LO;
            ST_HDR_LO:  st_n = ST_HDR_HI;
            ST_HDR_HI:  st_n = ST_IDLE;
            default:    st_n = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)
            res_q <= '{oc: OC_NONE, id: '0};
        else if (st == ST_WAIT) begin
            if (rx_valid)
                res_q <= classify(1'b1, rx_crc_ok, rx_id);
            else if (wd_exp)
                res_q <= classify(1'b0, 1'b0, rx_id);
        end
    end

    acs_wdog #(
        .LIM0(LIM0), .LIM1(LIM1), .LIM2(LIM2), .LIM3(LIM3), .CNT_W(CNT_W)
    ) i_wdog (
        .clk(clk), .rst(rst),
        .clr(st == ST_SEND),
        .run(st == ST_WAIT),
        .sel(wdg_sel),
        .expired(wd_exp)
    );

    acs_slot_ctr i_slot (
        .clk(clk), .rst(rst),
        .clr(launch),
        .adv((st == ST_STORE) && !last_slot),
        .slot(slot),
        .last(last_slot)
    );

    acs_status_reg i_stat (
        .clk(clk), .rst(rst),
        .clr(launch),
        .set_en(st == ST_STORE),
        .slot(slot),
        .ok(res_q.oc == OC_VALID),
        .status(status)
    );

    assign tx_req = (st == ST_SEND);
    assign tx_cmd = slot_cmd(slot, CALL_OPC, MARK_NIB);
    assign busy   = (st != ST_IDLE);
    assign done   = (st == ST_HDR_HI);

    always_comb begin
        buf_we    = 1'b0;
        buf_addr  = '0;
        buf_wdata = '0;
        case (st)
            ST_STORE: begin
                buf_we    = 1'b1;
                buf_addr  = ADDR_W'(ID_BASE) + ADDR_W'(slot);
                buf_wdata = res_q.id;
            end
            ST_HDR_LEN: begin
                buf_we    = 1'b1;
                buf_addr  = ADDR_W'(0);
                buf_wdata = 8'(LEN_VALUE);
            end
            ST_HDR_LO: begin
                buf_we    = 1'b1;
                buf_addr  = ADDR_W'(1);
                buf_wdata = status[7:0];
            end
            ST_HDR_HI: begin
                buf_we    = 1'b1;
                buf_addr  = ADDR_W'(2);
                buf_wdata = status[15:8];
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/acs_slot_scan_chk.sv
module acs_slot_scan_chk #(
    parameter int ADDR_W = 5
) (
    input logic              clk,
    input logic              rst,
    input logic              scan_start,
    input logic              xchg_busy,
    input logic              tx_req,
    input logic              buf_we,
    input logic [ADDR_W-1:0] buf_addr,
    input logic [7:0]        buf_wdata,
    input logic              busy,
    input logic              done
);
    // R1
    tx_in_scan_chk: assert property (@(posedge clk) disable iff (rst)
        tx_req |-> busy);

    // R1
    scan_opens_with_tx_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> tx_req);

    // R2
    tx_single_cycle_chk: assert property (@(posedge clk) disable iff (rst)
        tx_req |=> !tx_req);

    // R7
    blocked_start_chk: assert property (@(posedge clk) disable iff (rst)
        (!busy && xchg_busy) |=> !busy);

    // R10
    write_in_image_chk: assert property (@(posedge clk) disable iff (rst)
        buf_we |-> (buf_addr <= ADDR_W'(18)));

    // R6
    length_byte_chk: assert property (@(posedge clk) disable iff (rst)
        (buf_we && buf_addr == '0) |-> (buf_wdata == 8'd18));

    // R8
    done_with_hi_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> (buf_we && buf_addr == ADDR_W'(2)));

    // R8
    done_then_idle_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> (!busy && !done));
endmodule

bind acs_slot_scan acs_slot_scan_chk #(.ADDR_W(ADDR_W)) i_acs_chk (
    .clk(clk), .rst(rst), .scan_start(scan_start), .xchg_busy(xchg_busy),
    .tx_req(tx_req), .buf_we(buf_we), .buf_addr(buf_addr),
    .buf_wdata(buf_wdata), .busy(busy), .done(done)
);

// File: tb/test_acs_slot_scan.sv
module test_acs_slot_scan;
    localparam logic [7:0] CALL = 8'h06;
    localparam logic [3:0] MARK = 4'h6;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic scan_start = 1'b0, xchg_busy = 1'b0;
    logic [1:0] wdg_sel = 2'd0;
    logic tx_req;
    logic [7:0] tx_cmd;
    logic rx_valid = 1'b0, rx_crc_ok = 1'b0;
    logic [7:0] rx_id = 8'h00;
    logic buf_we;
    logic [4:0] buf_addr;
    logic [7:0] buf_wdata;
    logic busy, done;

    int checks = 0, errors = 0, cyc = 0;
    int kind[16];          // 0 none, 1 valid, 2 crc error, 3 late answer
    int dly[16];
    logic [7:0] idv[16];
    logic [7:0] cap[32];
    int wcnt[32], wcyc[32];
    int txcyc[16];
    logic [7:0] txcmd[16];
    int ntx = 0, ndone = 0, cd = 0, cur_lim = 12;
    bit stray_req = 1'b0;

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    acs_slot_scan #(.CALL_OPC(CALL), .MARK_NIB(MARK),
        .LIM0(12), .LIM1(20), .LIM2(28), .LIM3(36), .ADDR_W(5)) i_acs_slot_scan (
        .clk(clk), .rst(rst), .scan_start(scan_start), .xchg_busy(xchg_busy),
        .wdg_sel(wdg_sel), .tx_req(tx_req), .tx_cmd(tx_cmd),
        .rx_valid(rx_valid), .rx_crc_ok(rx_crc_ok), .rx_id(rx_id),
        .buf_we(buf_we), .buf_addr(buf_addr), .buf_wdata(buf_wdata),
        .busy(busy), .done(done));

    function automatic int lim_of(input int s);
        return 12 + 8 * s;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // responder and capture, all at the falling edge
    initial begin
        forever begin
            @(negedge clk);
            rx_valid = 1'b0;
            if (stray_req) begin
                rx_valid = 1'b1; rx_crc_ok = 1'b1; rx_id = 8'h3C; stray_req = 1'b0;
            end
            if (cd > 0) begin
                cd--;
                if (cd == 0) rx_valid = 1'b1;
            end
            if (buf_we) begin
                cap[buf_addr] = buf_wdata;
                wcnt[buf_addr]++;
                wcyc[buf_addr] = cyc;
            end
            if (done) ndone++;
            if (tx_req) begin
                if (ntx < 16) begin
                    txcmd[ntx] = tx_cmd;
                    txcyc[ntx] = cyc;
                    if (kind[ntx] != 0) begin
                        cd = (kind[ntx] == 3) ? cur_lim + 1 : dly[ntx];
                        rx_crc_ok = (kind[ntx] != 2);
                        rx_id = (kind[ntx] == 3) ? 8'h5A : idv[ntx];
                    end
                end
                ntx++;
            end
        end
    end

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    task automatic clear_cap();
        for (int i = 0; i < 32; i++) begin cap[i] = 8'hxx; wcnt[i] = 0; wcyc[i] = 0; end
        ntx = 0; ndone = 0; cd = 0;
    endtask

    task automatic run_scan(input int p);
        int sel, waited;
        logic [15:0] exp_stat;
        bit ok_cmd, ok_once, ok_lat, ok_id;
        sel = p % 4;
        cur_lim = lim_of(sel);
        for (int s = 0; s < 16; s++) begin
            if (p == 0)      kind[s] = 0;
            else if (p == 1) kind[s] = 1;
            else if (p == 2) kind[s] = 2;
            else             kind[s] = (s * 3 + p) % 4;
            idv[s] = (p == 1) ? 8'(s * 17) : 8'(s * 37 + p * 11);
            dly[s] = ((s + p) % 2 == 1) ? cur_lim : 1 + (s % 3);
        end
        @(negedge clk);
        clear_cap();
        wdg_sel = 2'(sel);
        scan_start = 1'b1;
        @(negedge clk);
        scan_start = 1'b0;
        // R1: busy and tx_req visible in the cycle after the start sample
        chk(busy && tx_req, "R1 start response", int'({busy, tx_req}), 3);
        waited = 0;
        while (ndone == 0 && waited < 3000) begin
            if (p == 4 && ntx == 5 && waited < 2000) begin
                scan_start = 1'b1;      // R7 start during running scan
                @(negedge clk);
                scan_start = 1'b0;
                waited = 2000;
            end else begin
                @(negedge clk);
                waited++;
            end
        end
        @(negedge clk);
        chk(!busy, "R8 idle after done", int'(busy), 0);
        repeat (3) @(negedge clk);
        chk(ndone == 1, "R8 one done pulse", ndone, 1);
        chk(ntx == 16, "R2 request count", ntx, 16);
        ok_cmd = 1'b1;
        for (int s = 0; s < 16; s++)
            if (txcmd[s] !== ((s == 0) ? CALL : {4'(s), MARK})) ok_cmd = 1'b0;
        chk(ok_cmd, "R2 command bytes", int'(txcmd[1]), int'({4'd1, MARK}));
        ok_once = 1'b1;
        for (int a = 0; a < 32; a++)
            if (wcnt[a] != ((a <= 18) ? 1 : 0)) ok_once = 1'b0;
        chk(ok_once, "R10 write once per byte", wcnt[0], 1);
        exp_stat = '0;
        ok_lat = 1'b1;
        for (int s = 0; s < 16; s++) begin
            logic [7:0] e;
            int lat;
            e = (kind[s] == 1) ? idv[s] : (kind[s] == 2) ? 8'hFF : 8'h00;
            if (kind[s] == 1) exp_stat[s] = 1'b1;
            ok_id = (cap[3 + s] === e);
            if (kind[s] == 1)      chk(ok_id, "R3 valid id", int'(cap[3+s]), int'(e));
            else if (kind[s] == 2) chk(ok_id, "R5 crc sentinel", int'(cap[3+s]), int'(e));
            else if (kind[s] == 3) chk(ok_id, "R9 late answer ignored", int'(cap[3+s]), int'(e));
            else                   chk(ok_id, "R4 no answer sentinel", int'(cap[3+s]), int'(e));
            lat = (kind[s] == 1 || kind[s] == 2) ? dly[s] + 1 : cur_lim + 1;
            if (wcyc[3 + s] - txcyc[s] != lat) ok_lat = 1'b0;
        end
        chk(ok_lat, "R4 window timing", wcyc[3] - txcyc[0], 0);
        chk(cap[0] === 8'd18, "R6 length byte", int'(cap[0]), 18);
        chk(cap[1] === exp_stat[7:0], "R6 status low", int'(cap[1]), int'(exp_stat[7:0]));
        chk(cap[2] === exp_stat[15:8], "R6 status high", int'(cap[2]), int'(exp_stat[15:8]));
        chk(wcyc[2] == wcyc[1] + 1, "R8 done with last header", wcyc[2] - wcyc[1], 1);
    endtask

    initial begin
        for (int s = 0; s < 16; s++) begin kind[s] = 0; dly[s] = 1; idv[s] = 8'h00; end
        clear_cap();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(!busy && !tx_req && !done && !buf_we, "R1 reset state",
            int'({busy, tx_req, done, buf_we}), 0);
        // R7: start while exchange busy is ignored
        xchg_busy = 1'b1;
        scan_start = 1'b1;
        @(negedge clk);
        scan_start = 1'b0;
        repeat (4) @(negedge clk);
        chk(!busy && ntx == 0, "R7 blocked by exchange", ntx, 0);
        xchg_busy = 1'b0;
        // R9: stray answer while idle writes nothing
        stray_req = 1'b1;
        repeat (4) @(negedge clk);
        chk(wcnt[3] == 0 && !busy, "R9 idle answer ignored", wcnt[3], 0);
        for (int p = 0; p < 8; p++) run_scan(p);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule